// File: doc/BRIEF.md
# PDM Microphone Capture and CIC Decimator

This block connects one PDM microphone to a chip's audio path. A programmable integer divider with a 50% duty cycle derives the microphone bit clock from the faster core clock. The block samples the one-bit data pin in the core clock domain, on the core edge where that bit clock rises. A four-stage cascaded integrator-comb (CIC) filter then turns the bit stream into signed PCM samples. Software selects an oversampling ratio of 64 or 128, and may change it while the block runs. The output sample rate is the bit clock frequency divided by that ratio. For example, a 48 kHz output needs a 6.144 MHz bit clock at ratio 128, or 3.072 MHz at ratio 64.

Each comb result is shifted right arithmetically by an amount tied to the ratio. It is then saturated into a signed 24-bit word and presented with a one-cycle valid strobe. Dropping the enable, or changing the ratio, empties the filter so that no history from the old setting leaks into new samples.

Top module: `pdm_decim`

## Requirements
- R1: While `en_i` is low, `pdm_clk_o` is low. When enabled, its high and low phases each last `clk_div_i` core cycles, and a value of 0 acts as 1.
- R2: `pdm_dat_i` is taken only at the core clock edge where `pdm_clk_o` goes from 0 to 1. Changes to it at any other time have no effect on the samples.
- R3: A sampled 1 counts as +1 and a 0 as −1. For a periodic bit pattern with a fraction d of ones, the settled output equals (2d−1)·2^23 at either ratio. Examples: three ones in four give 4194304, one in four gives −4194304, and alternating bits give 0.
- R4: Results outside the signed 24-bit range are clamped. A constant 1 input settles at 8388607 and a constant 0 input at −8388608, at either ratio.
- R5: `osr_sel_i`=0 selects ratio R=64 and 1 selects R=128. `pcm_valid_o` is a single-cycle pulse, once per R sampled bits (2·R·`clk_div_i` core cycles). Each pulse coincides with a rising edge of `pdm_clk_o`. `pcm_o` changes only at a pulse or when disabled.
- R6: A change of `osr_sel_i` while enabled clears the bit clock, the divider, the integrators, the combs and the bit counter in the core edge that first sees it. The first new pulse appears after the ((2R−1)·`clk_div_i`+1)-th core edge, counting that edge as the first.
- R7: Deasserting `en_i` clears all filter state and sets `pcm_o` to 0 at the next edge, and no pulse occurs while disabled. After re-enabling, the first pulse appears after the ((2R−1)·`clk_div_i`)-th core edge.
- R8: Under reset, `pdm_clk_o`, `pcm_valid_o` and `pcm_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low clears the block |
| osr_sel_i | input | 1 | Oversampling ratio: 0 = 64, 1 = 128 |
| clk_div_i | input | DIV_W | Core cycles per bit clock half period |
| pdm_dat_i | input | 1 | Microphone data pin |
| pdm_clk_o | output | 1 | Microphone bit clock |
| pcm_o | output | OUT_W | Signed decimated sample |
| pcm_valid_o | output | 1 | One-cycle strobe for a new sample |

## Verification
The hardest case to reach from the ports is a filter whose every stage holds a known settled state. Exact expected values only exist once the four-stage window has been filled completely with a periodic pattern. For this reason the stimulus drives patterns whose period divides both ratios, and the checks ignore the first five outputs after each clear. The stimulus model also tracks the generated bit clock. It inverts the data pin throughout every high phase, so only a design that samples at the rising edge reproduces the expected values. The ratio switch is timed right after a pulse, so the edge count to the next pulse reflects the clearing of the counter and the divider alone.

// File: rtl/pdm_decim_pkg.sv
package pdm_decim_pkg;
  typedef enum logic {OSR_64 = 1'b0, OSR_128 = 1'b1} osr_e;

  // right shift that maps CIC full scale (R^N) onto 2^(out_w-1)
  function automatic int unsigned cic_shift(input int unsigned n_stages,
                                            input int unsigned log2_r,
                                            input int unsigned out_w);
    return n_stages * log2_r + 1 - out_w;
  endfunction
endpackage

// File: rtl/pdm_clkgen.sv
module pdm_clkgen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             pdm_clk_o,
  output logic             rise_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             clk_q;

  assign lim       = (div_i == '0) ? '0 : div_i - 1'b1;
  assign pdm_clk_o = clk_q;
  assign rise_o    = !clr_i && (cnt_q == lim) && !clk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      clk_q <= 1'b0;
    end else if (cnt_q == lim) begin
      cnt_q <= '0;
      clk_q <= ~clk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r1_clear_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!pdm_clk_o && cnt_q == '0));
  a_r2_rise_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> pdm_clk_o);
endmodule

// File: rtl/pdm_cic.sv
module pdm_cic #(
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned ACC_W    = 30,
  parameter int unsigned CNT_W    = 7
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    tick_i,
  input  logic                    bit_i,
  input  logic                    osr_hi_i,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    dec_o
);
  localparam logic [CNT_W-1:0] LIM_HI = '1;
  localparam logic [CNT_W-1:0] LIM_LO = LIM_HI >> 1;

  logic signed [ACC_W-1:0] integ_q [N_STAGES];
  logic signed [ACC_W-1:0] dly_q   [N_STAGES];
  logic signed [ACC_W-1:0] cin     [N_STAGES];
  logic signed [ACC_W-1:0] x;
  logic [CNT_W-1:0]        cnt_q;
  logic [CNT_W-1:0]        lim;

  assign x     = bit_i ? {{(ACC_W-1){1'b0}}, 1'b1} : '1;
  assign lim   = osr_hi_i ? LIM_HI : LIM_LO;
  assign dec_o = tick_i && (cnt_q == lim);

  // comb chain at the decimated rate
  always_comb begin
    logic signed [ACC_W-1:0] v;
    v = integ_q[N_STAGES-1];
    for (int k = 0; k < N_STAGES; k++) begin
      cin[k] = v;
      v = v - dly_q[k];
    end
    y_o = v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int k = 0; k < N_STAGES; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
    end else if (clr_i) begin
      cnt_q <= '0;
      for (int k = 0; k < N_STAGES; k++) begin
        integ_q[k] <= '0;
        dly_q[k]   <= '0;
      end
    end else if (tick_i) begin
      integ_q[0] <= integ_q[0] + x;
      for (int k = 1; k < N_STAGES; k++) integ_q[k] <= integ_q[k] + integ_q[k-1];
      cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
      if (cnt_q == lim)
        for (int k = 0; k < N_STAGES; k++) dly_q[k] <= cin[k];
    end
  end

  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim);
  a_r6_clear_cnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0 && !dec_o));
endmodule

// File: rtl/pdm_sat_scale.sv
module pdm_sat_scale #(
  parameter int unsigned ACC_W = 30,
  parameter int unsigned OUT_W = 24,
  parameter int unsigned SH_HI = 5,
  parameter int unsigned SH_LO = 1
) (
  input  logic signed [ACC_W-1:0] y_i,
  input  logic                    osr_hi_i,
  output logic signed [OUT_W-1:0] q_o
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - 1;

  logic signed [ACC_W-1:0] sh;

  assign sh  = osr_hi_i ? (y_i >>> SH_HI) : (y_i >>> SH_LO);
  assign q_o = (sh > MAXV) ? MAXV[OUT_W-1:0] :
               (sh < MINV) ? MINV[OUT_W-1:0] : sh[OUT_W-1:0];
endmodule

// File: rtl/pdm_decim.sv
module pdm_decim
  import pdm_decim_pkg::*;
#(
  parameter int unsigned DIV_W    = 8,
  parameter int unsigned N_STAGES = 4,
  parameter int unsigned OUT_W    = 24
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    osr_sel_i,
  input  logic [DIV_W-1:0]        clk_div_i,
  input  logic                    pdm_dat_i,
  output logic                    pdm_clk_o,
  output logic signed [OUT_W-1:0] pcm_o,
  output logic                    pcm_valid_o
);
  localparam int unsigned LOG2_HI = 7;
  localparam int unsigned LOG2_LO = 6;
  localparam int unsigned ACC_W   = N_STAGES * LOG2_HI + 2;
  localparam int unsigned SH_HI   = cic_shift(N_STAGES, LOG2_HI, OUT_W);
  localparam int unsigned SH_LO   = cic_shift(N_STAGES, LOG2_LO, OUT_W);

  osr_e                    osr_q;
  logic                    clr, rise, dec;
  logic signed [ACC_W-1:0] cic_y;
  logic signed [OUT_W-1:0] scaled;

  assign clr = !en_i || (osr_e'(osr_sel_i) != osr_q);

  pdm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i, .rst_ni, .clr_i(clr), .div_i(clk_div_i),
    .pdm_clk_o, .rise_o(rise)
  );

  pdm_cic #(.N_STAGES(N_STAGES), .ACC_W(ACC_W), .CNT_W(LOG2_HI)) u_cic (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(rise), .bit_i(pdm_dat_i),
    .osr_hi_i(osr_q == OSR_128), .y_o(cic_y), .dec_o(dec)
  );

  pdm_sat_scale #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SH_HI(SH_HI), .SH_LO(SH_LO)) u_scale (
    .y_i(cic_y), .osr_hi_i(osr_q == OSR_128), .q_o(scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osr_q       <= OSR_64;
      pcm_o       <= '0;
      pcm_valid_o <= 1'b0;
    end else begin
      osr_q       <= osr_e'(osr_sel_i);
      pcm_valid_o <= dec && !clr;
      if (!en_i)           pcm_o <= '0;
      else if (dec && !clr) pcm_o <= scaled;
    end
  end

  a_r5_valid_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |-> $rose(pdm_clk_o));
  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcm_valid_o |=> !pcm_valid_o);
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !pcm_valid_o) |-> $stable(pcm_o));
  a_r6_switch_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && osr_e'(osr_sel_i) != osr_q) |=> (!pdm_clk_o && !pcm_valid_o));
  a_r7_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pdm_clk_o && !pcm_valid_o && pcm_o == '0));
endmodule

// File: tb/pdm_decim_test.sv
module pdm_decim_test;
  typedef struct packed {
    logic [2:0]         mode;   // 0 ones,1 zeros,2 alternate,3 three-in-four,4 one-in-four
    logic               osr;
    logic [7:0]         div;
    logic               glitch;
    logic               sat;
    logic signed [23:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{mode:3'd0, osr:1'b1, div:8'd2, glitch:1'b0, sat:1'b1, exp:24'sd8388607},
    '{mode:3'd1, osr:1'b0, div:8'd1, glitch:1'b1, sat:1'b1, exp:-24'sd8388608},
    '{mode:3'd2, osr:1'b1, div:8'd3, glitch:1'b1, sat:1'b0, exp:24'sd0},
    '{mode:3'd3, osr:1'b0, div:8'd2, glitch:1'b1, sat:1'b0, exp:24'sd4194304},
    '{mode:3'd4, osr:1'b1, div:8'd1, glitch:1'b0, sat:1'b0, exp:-24'sd4194304},
    '{mode:3'd3, osr:1'b1, div:8'd1, glitch:1'b1, sat:1'b0, exp:24'sd4194304},
    '{mode:3'd0, osr:1'b0, div:8'd2, glitch:1'b0, sat:1'b1, exp:24'sd8388607}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0, en_i = 1'b0, osr_sel_i = 1'b0, pdm_dat_i = 1'b0;
  logic [7:0] clk_div_i = 8'd2;
  logic pdm_clk_o, pcm_valid_o;
  logic signed [23:0] pcm_o;

  int checks = 0, errors = 0;
  int bit_idx = 0;
  logic last_pc = 1'b0;
  logic [2:0] mode = 3'd0;
  logic glitch = 1'b0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  pdm_decim uut (
    .clk_i, .rst_ni, .en_i, .osr_sel_i, .clk_div_i, .pdm_dat_i,
    .pdm_clk_o, .pcm_o, .pcm_valid_o
  );

  function automatic logic pat(input logic [2:0] m, input int i);
    case (m)
      3'd0: return 1'b1;
      3'd1: return 1'b0;
      3'd2: return i[0];
      3'd3: return i[1:0] != 2'd0;
      default: return i[1:0] == 2'd0;
    endcase
  endfunction

  // microphone model: stable during low phase, inverted during high phase when glitching
  always @(negedge clk_i) begin
    if (pdm_clk_o && !last_pc) bit_idx = bit_idx + 1;
    last_pc = pdm_clk_o;
    pdm_dat_i = (pdm_clk_o && glitch) ? ~pat(mode, bit_idx) : pat(mode, bit_idx);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int nval, t7;
    en_i = 1'b0;
    repeat (4) @(negedge clk_i);
    mode = v.mode; osr_sel_i = v.osr; clk_div_i = v.div; glitch = v.glitch;
    en_i = 1'b1;
    nval = 0; t7 = 0;
    while (nval < 8) begin
      @(negedge clk_i);
      if (pcm_valid_o) begin
        nval++;
        if (nval >= 6) chk(v.sat ? "R4 saturated level" : "R3/R2 settled level",
                           longint'(pcm_o), longint'(v.exp));
        if (nval == 7) t7 = cyc;
        if (nval == 8) chk("R5 pulse spacing", cyc - t7,
                           2 * (v.osr ? 128 : 64) * int'(v.div));
      end
    end
  endtask

  task automatic phase_len(input logic [7:0] d, input int exp);
    int n;
    en_i = 1'b0; clk_div_i = d;
    repeat (2) @(negedge clk_i);
    en_i = 1'b1;
    while (!pdm_clk_o) @(negedge clk_i);
    n = 0;
    while (pdm_clk_o) begin @(negedge clk_i); n++; end
    chk("R1 high phase", n, exp);
    n = 0;
    while (!pdm_clk_o) begin @(negedge clk_i); n++; end
    chk("R1 low phase", n, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic seen;
    repeat (3) @(negedge clk_i);
    chk("R8 clock in reset", pdm_clk_o, 0);
    chk("R8 valid in reset", pcm_valid_o, 0);
    chk("R8 sample in reset", pcm_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R7: disable clears and stays quiet
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R7 sample cleared", pcm_o, 0);
    seen = 1'b0;
    repeat (400) begin
      @(negedge clk_i);
      if (pcm_valid_o || pdm_clk_o) seen = 1'b1;
    end
    chk("R7 quiet while disabled", seen, 0);

    // R1 phase lengths, including the zero setting
    phase_len(8'd3, 3);
    phase_len(8'd0, 1);

    // R7 latency after enable
    en_i = 1'b0; mode = 3'd0; glitch = 1'b0; osr_sel_i = 1'b0; clk_div_i = 8'd2;
    repeat (3) @(negedge clk_i);
    en_i = 1'b1;
    n = 0;
    do begin @(posedge clk_i); n++; @(negedge clk_i); end while (!pcm_valid_o);
    chk("R7 enable latency", n, (2 * 64 - 1) * 2);

    // R6 ratio switch right after a pulse
    repeat (4) begin
      do @(negedge clk_i); while (!pcm_valid_o);
    end
    osr_sel_i = 1'b1;
    n = 0;
    do begin @(posedge clk_i); n++; @(negedge clk_i); end while (!pcm_valid_o);
    chk("R6 switch latency", n, (2 * 128 - 1) * 2 + 1);
    repeat (6) begin
      do @(negedge clk_i); while (!pcm_valid_o);
    end
    chk("R6 level after switch", pcm_o, 8388607);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule